// File: doc/BRIEF.md
# CAN Transmit Dominant-Timeout Guard

This block sits between a CAN protocol controller and the line driver of a CAN physical layer. It decides, on every clock, whether the driver may be switched on and whether it should drive a dominant level. Three conditions turn the driver off: a listen-only input, an over-temperature flag, and a latched stuck-dominant fault. The receive path never passes through this block, so listen-only operation only silences transmission.

The stuck-dominant protection measures time in clock cycles. A synchronized high-to-low transition on the transmit data starts a saturating counter. If the counter reaches `TOUT_CYCLES` before transmit data returns high, a fault is latched. The fault keeps the driver off, and so the bus recessive, even while the controller keeps holding transmit data low. Only the next synchronized low-to-high transition of the transmit data clears the fault. Changes of the listen-only or temperature inputs do not clear it and do not restart the count.

All three asynchronous inputs pass through a two-stage synchronizer. Edges are detected on the synchronized transmit signal. Every port is a plain level signal. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `cantx_guard`

## Requirements
- R1: On synchronous reset `drv_en`, `drv_dom` and `tout_fault` are 0. The driver stays off, and no fault can build up, until the synchronized transmit input has been seen high at least once.
- R2: With `silent_in` and `overtemp_in` low and no fault latched, `txd_in` = 0 gives `drv_en` = 1 and `drv_dom` = 1. `txd_in` = 1 gives `drv_en` = 1 and `drv_dom` = 0 (recessive, driver released).
- R3: While the synchronized `silent_in` is 1, `drv_en` and `drv_dom` are 0 whatever `txd_in` is.
- R4: While the synchronized `overtemp_in` is 1, `drv_en` and `drv_dom` are 0.
- R5: `tout_fault` becomes 1 after the synchronized transmit input has been low for exactly `TOUT_CYCLES` consecutive cycles following a falling edge. From then on `drv_en` and `drv_dom` are 0 although `txd_in` is still 0. A low run of `TOUT_CYCLES`-1 cycles never sets the fault.
- R6: A latched fault stays set through changes of `silent_in` and `overtemp_in`. It clears one cycle after the synchronized rising edge of `txd_in`, and normal driving then resumes.
- R7: The dominant timer keeps counting regardless of `silent_in`. A low run that starts or continues in listen-only mode still latches the fault, and toggling `silent_in` mid-run does not restart the count.
- R8: The counter saturates. A dominant run many times longer than `TOUT_CYCLES` keeps `tout_fault` at 1 and never re-enables the driver.
- R9: Each input reaches the outputs through two register stages. A change of `txd_in`, `silent_in` or `overtemp_in` shows on `drv_en`/`drv_dom` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_in | input | 1 | Transmit data from the controller; 0 = dominant |
| silent_in | input | 1 | Listen-only request; 1 turns the driver off |
| overtemp_in | input | 1 | Over-temperature flag; 1 turns the driver off |
| drv_en | output | 1 | Driver enable; 0 leaves the bus lines high impedance |
| drv_dom | output | 1 | Drive a dominant level (only while drv_en is 1) |
| tout_fault | output | 1 | Latched stuck-dominant fault status |

## Verification
The assertions check on every cycle that a synchronized listen-only or over-temperature level, or a latched fault, keeps the driver off. They also check that dominant is never requested without enable, that the fault only rises after a low transmit sample, and that it holds until a rising edge and clears right after one. Only the bench scenarios can show the exact length of the timeout on both sides of the limit, the saturation over a long dominant run, the fault surviving mode changes, the requirement for a first high sample after reset, and the two-edge input latency.

// File: rtl/cantx_guard_pkg.sv
package cantx_guard_pkg;

  // Synchronized view of the three asynchronous control inputs.
  typedef struct packed {
    logic txd;
    logic silent;
    logic hot;
  } guard_in_t;

  localparam int unsigned GUARD_IN_W = $bits(guard_in_t);

  // Safe values held in the synchronizer during reset: transmit looks
  // dominant (so arming needs a real high), listen-only and hot asserted.
  localparam guard_in_t GUARD_IN_RST = '{txd: 1'b0, silent: 1'b1, hot: 1'b1};

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cantx_sync.sv
module cantx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cantx_dom_timer.sv
module cantx_dom_timer #(
  parameter int unsigned TOUT_CYCLES = 60000
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_s,
  output logic armed,
  output logic fault
);

  localparam int unsigned CW = cantx_guard_pkg::cnt_width(TOUT_CYCLES);
  localparam logic [CW-1:0] LIM    = CW'(TOUT_CYCLES);
  localparam logic [CW-1:0] LIM_M1 = CW'(TOUT_CYCLES - 1);

  logic          txd_prev;
  logic [CW-1:0] cnt_q;
  logic          fall, rise, counting;

  assign fall     = txd_prev & ~txd_s;
  assign rise     = ~txd_prev & txd_s;
  // Counting only after a falling edge has loaded the counter; it stops at LIM.
  assign counting = ~txd_s & (cnt_q != '0) & (cnt_q != LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_prev <= 1'b0;
      cnt_q    <= '0;
      fault    <= 1'b0;
      armed    <= 1'b0;
    end else begin
      txd_prev <= txd_s;
      armed    <= armed | txd_s;
      if (rise) begin
        cnt_q <= '0;
        fault <= 1'b0;
      end else if (fall) begin
        cnt_q <= CW'(1);
        if (LIM == CW'(1)) fault <= 1'b1;
      end else if (counting) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LIM_M1) fault <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cantx_drv_ctrl.sv
module cantx_drv_ctrl (
  input  logic armed,
  input  logic fault,
  input  cantx_guard_pkg::guard_in_t in_s,
  output logic drv_en,
  output logic drv_dom
);

  assign drv_en  = armed & ~fault & ~in_s.silent & ~in_s.hot;
  assign drv_dom = drv_en & ~in_s.txd;

endmodule

// File: rtl/cantx_guard.sv
module cantx_guard #(
  parameter int unsigned TOUT_CYCLES = 60000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  input  logic silent_in,
  input  logic overtemp_in,
  output logic drv_en,
  output logic drv_dom,
  output logic tout_fault
);
  import cantx_guard_pkg::*;

  guard_in_t raw_in, in_s;
  logic      txd_s, silent_s, hot_s;
  logic      armed;

  assign raw_in = '{txd: txd_in, silent: silent_in, hot: overtemp_in};

  cantx_sync #(
    .W       (GUARD_IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (GUARD_IN_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (in_s)
  );

  assign txd_s    = in_s.txd;
  assign silent_s = in_s.silent;
  assign hot_s    = in_s.hot;

  cantx_dom_timer #(
    .TOUT_CYCLES (TOUT_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .txd_s (txd_s),
    .armed (armed),
    .fault (tout_fault)
  );

  cantx_drv_ctrl u_ctrl (
    .armed   (armed),
    .fault   (tout_fault),
    .in_s    (in_s),
    .drv_en  (drv_en),
    .drv_dom (drv_dom)
  );

endmodule

// File: rtl/cantx_guard_chk.sv
module cantx_guard_chk (
  input logic clk,
  input logic rst,
  input logic txd_s,
  input logic silent_s,
  input logic hot_s,
  input logic drv_en,
  input logic drv_dom,
  input logic tout_fault
);

  p_dom_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    drv_dom |-> drv_en);

  p_silent_off_r3: assert property (@(posedge clk) disable iff (rst)
    silent_s |-> (!drv_en && !drv_dom));

  p_hot_off_r4: assert property (@(posedge clk) disable iff (rst)
    hot_s |-> (!drv_en && !drv_dom));

  p_fault_off_r5: assert property (@(posedge clk) disable iff (rst)
    tout_fault |-> (!drv_en && !drv_dom));

  p_fault_after_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tout_fault) |-> $past(!txd_s));

  p_fault_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tout_fault && !txd_s) |=> tout_fault);

  p_fault_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(txd_s) |=> !tout_fault);

endmodule

bind cantx_guard cantx_guard_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .txd_s      (txd_s),
  .silent_s   (silent_s),
  .hot_s      (hot_s),
  .drv_en     (drv_en),
  .drv_dom    (drv_dom),
  .tout_fault (tout_fault)
);

// File: tb/cantx_guard_test.sv
module cantx_guard_test;

  localparam int unsigned T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd_in = 1'b1;
  logic silent_in = 1'b0;
  logic overtemp_in = 1'b0;
  logic drv_en, drv_dom, tout_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cantx_guard #(.TOUT_CYCLES(T)) uut (
    .clk         (clk),
    .rst         (rst),
    .txd_in      (txd_in),
    .silent_in   (silent_in),
    .overtemp_in (overtemp_in),
    .drv_en      (drv_en),
    .drv_dom     (drv_dom),
    .tout_fault  (tout_fault)
  );

  // Vector: {txd, silent, hot, exp_en, exp_dom}
  localparam logic [4:0] VEC [10] = '{
    5'b1_0_0_1_0, 5'b0_0_0_1_1, 5'b1_0_0_1_0, 5'b0_1_0_0_0, 5'b1_1_0_0_0,
    5'b0_0_1_0_0, 5'b1_0_1_0_0, 5'b0_0_0_1_1, 5'b1_1_1_0_0, 5'b1_0_0_1_0
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {drv_en, drv_dom, tout_fault};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {en,dom,fault} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with transmit held low; no arming, no fault buildup
    txd_in = 1'b0;
    step(3);
    chk("R1 reset", 3'b000);
    rst = 1'b0;
    step(T + 10);
    chk("R1 unarmed low", 3'b000);
    txd_in = 1'b1;
    step(4);
    chk("R1 armed by high", 3'b100);

    // Table walk (R2 R3 R4)
    for (int i = 0; i < 10; i++) begin
      txd_in      = VEC[i][4];
      silent_in   = VEC[i][3];
      overtemp_in = VEC[i][2];
      step(3);
      chk("R2/R3/R4 table", {VEC[i][1], VEC[i][0], 1'b0});
    end

    // R9: two-edge latency on transmit path
    txd_in = 1'b0;
    step(1);
    chk("R9 one edge", 3'b100);
    step(1);
    chk("R9 two edges", 3'b110);
    txd_in = 1'b1;
    step(3);

    // R5 lower boundary: T-1 low cycles never fault
    txd_in = 1'b0;
    step(T - 1);
    txd_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      checks++;
      if (tout_fault !== 1'b0) begin
        errors++;
        $display("FAIL R5 short run: fault actual=%b expected=0", tout_fault);
      end
    end

    // R5 exact limit
    txd_in = 1'b0;
    step(T + 1);
    chk("R5 just before limit", 3'b110);
    step(1);
    chk("R5 at limit", 3'b001);

    // R8 saturation
    step(3 * T);
    chk("R8 long dominant", 3'b001);

    // R6 fault survives mode changes
    silent_in = 1'b1; step(3);
    silent_in = 1'b0; step(3);
    chk("R6 after silent toggle", 3'b001);
    overtemp_in = 1'b1; step(3);
    overtemp_in = 1'b0; step(3);
    chk("R6 after hot toggle", 3'b001);
    txd_in = 1'b1;
    step(2);
    chk("R6 before clear", 3'b001);
    step(1);
    chk("R6 cleared", 3'b100);
    txd_in = 1'b0;
    step(2);
    chk("R6 resumed", 3'b110);
    txd_in = 1'b1;
    step(3);

    // R7 timer runs in listen-only mode
    silent_in = 1'b1;
    txd_in = 1'b0;
    step(T + 2);
    chk("R7 silent fault", 3'b001);
    silent_in = 1'b0;
    step(3);
    chk("R7 leave silent", 3'b001);
    txd_in = 1'b1;
    step(3);
    chk("R7 clear", 3'b100);

    // R7 silent toggle mid-run does not restart the count
    txd_in = 1'b0;
    step(10);
    silent_in = 1'b1;
    step(5);
    silent_in = 1'b0;
    step(T + 1 - 15);
    chk("R7 mid-run before limit", 3'b110);
    step(1);
    chk("R7 mid-run at limit", 3'b001);

    // R1 reset clears a latched fault
    rst = 1'b1;
    step(2);
    chk("R1 reset clears fault", 3'b000);
    rst = 1'b0;
    txd_in = 1'b1;
    step(4);
    chk("R1 rearm", 3'b100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule